// File: doc/BRIEF.md
# Network Input Command and Configuration Register Port

This block is the processor-facing side of a network receive unit. It lets the processor steer remote-operation replies by writing command words, feed reply data, read what the unit received, learn whether the last reply was acknowledged, and hold the unit's whole-word configuration. All of this goes through a single 32-bit data path. That path appears at several word addresses, and each address gives a read or write its own meaning.

Two copies of the unit share a node. They are told apart by the region of word addresses they decode, chosen by a parameter. A connection state machine tracks where the current remote operation stands:

- **IDLE**: no open connection.
- **AWAIT_CMD**: a connection is open and the unit waits for a command.
- **AWAIT_DATA**: the unit waits for reply data.
- **DRAIN**: the reply is out and the unit waits for the transaction engine's acknowledge.

The transitions are named *open*, *respond*, *respond_final*, *end_now*, *data_end*, *acked_more*, *acked_last* and *abort*. A second, two-state bus machine (**BS_IDLE**, **BS_DONE**) answers each access with a one-cycle ready.

Accepted commands and data words go to the transaction engine as one-cycle pulses. A malformed command word raises a sticky error. That error is visible in the state register and on an error output.

Top module: `netin_cmd_port`

## Requirements
- R1: **Address map.** Word address `UNIT_BASE + k` selects a register:
  - k=0: command
  - k=1: configuration
  - k=2: state
  - k=3: acknowledge
  - k=4: data

  `UNIT_BASE` is `MASTER_BASE` (0x000080) when `IS_SLAVE`=0, otherwise `SLAVE_BASE` (0x000088). An access to k=5..7, or to any address outside the unit's region, is still answered with ready. Such a read returns 0, and such a write changes nothing.
- R2: **Bus handshake.** `bus_ready` is high for exactly one cycle, in the cycle after the one whose clock edge sampled `bus_sel` while the bus was idle. Read data is valid in that ready cycle.
- R3: **Malformed command word.** A command word is malformed if bits 31:8 are not zero, or if bits 7:0 fall outside 1..5. Such a word:
  - sets the sticky error, bit 3 of the state register;
  - drives `err_irq` high;
  - issues no command;
  - leaves the connection state unchanged.
- R4: **Command codes.** The codes are 1 DATAEND, 2 ENDNOW, 3 RESPOND, 4 RESPONDFINAL and 5 ABORT. An accepted command raises `cmd_valid` for one cycle, together with `cmd_code`, in the ready cycle of the write.
- R5: **Open.** In IDLE, a `conn_open` pulse moves the unit to AWAIT_CMD.
- R6: **Commands in AWAIT_CMD.**
  - RESPOND goes to AWAIT_DATA with the final flag clear.
  - RESPONDFINAL goes to AWAIT_DATA with the final flag set.
  - ENDNOW goes to IDLE.
- R7: **Data writes.** In AWAIT_DATA, a write to the data register is forwarded: `dat_valid` pulses with `dat_word` in the ready cycle. In any other state such a write is dropped and `dat_valid` stays low.
- R8: **Drain.** In AWAIT_DATA, DATAEND moves the unit to DRAIN. In DRAIN, an `ack_valid` pulse moves the unit to IDLE if the final flag is set, otherwise to AWAIT_CMD.
- R9: **Abort.** ABORT is accepted in every state. It returns the unit to IDLE and clears the final flag and the error.
- R10: **Well-formed but out of place.** A well-formed command that is not legal in the current state is ignored. It issues no command, sets no error and leaves the state unchanged.
- R11: **Configuration register.** It is written only as a whole word. Its fields are:

  | Field | Bits | Width |
  |---|---|---|
  | dummy-cycle count | `[DUMMY_W-1:0]` | `DUMMY_W` (6) |
  | stage count | `[8 +: STAGE_W]` | `STAGE_W` (4) |
  | node number | `[16 +: NODE_W]` | `NODE_W` (12) |
  | polled-only flag | bit 31 | 1 |

  All fields reset to 0, so polled-only starts deasserted. Other bits read as 0.
- R12: **Acknowledge register.** Bit 0 holds `ack_ok` from the latest `ack_valid` pulse: 1 means the reply checksum was good, 0 means it failed. Bit 0 resets to 0. Bits 31:1 read as 0.
- R13: **State register.** The state register reads as follows:

  | Bit | Meaning |
  |---|---|
  | 0 | busy (not IDLE) |
  | 1 | AWAIT_DATA |
  | 2 | AWAIT_CMD |
  | 3 | error |
  | 4 | DRAIN |
  | 5 | final flag |
  | others | 0 |

- R14: **Data register read.** A read of the data register returns `rx_word` and pulses `rx_pop` in the ready cycle. No other access pulses `rx_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (22) | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle access completion |
| conn_open | input | 1 | Engine: a remote operation has opened a connection |
| ack_valid | input | 1 | Engine: reply acknowledge arrived |
| ack_ok | input | 1 | Engine: reply checksum was good |
| rx_word | input | 32 | Engine: received word offered to the processor |
| rx_pop | output | 1 | Received word consumed |
| cmd_valid | output | 1 | Command pulse to the engine |
| cmd_code | output | 3 | Command code |
| dat_valid | output | 1 | Reply data word pulse |
| dat_word | output | 32 | Reply data word |
| cfg_dummy | output | DUMMY_W (6) | Dummy cycles between real network cycles |
| cfg_stages | output | STAGE_W (4) | Network stage count |
| cfg_node | output | NODE_W (12) | Node number |
| cfg_polled | output | 1 | Polled-only mode |
| err_irq | output | 1 | Sticky command-word error |

## Verification
The bench sweeps all 256 low-byte codes from the AWAIT_CMD state, and walks a single set bit through each of the upper 24 bits of a command word. These sweeps catch three kinds of error:

- a design that decodes only the low byte would take a polluted word as a command;
- a design with an off-by-one in the legal range would accept 0 or 6 or reject 5;
- a design that flags out-of-place codes as errors would raise `err_irq` on DATAEND in AWAIT_CMD.

Aliasing is probed from three sides: the other unit's region, the unused offsets 5..7 and the next region up. An over-wide address compare would let writes there corrupt the configuration or issue commands. The two-turn reply flow checks that DRAIN returns to AWAIT_CMD only while the final flag is clear, and that data writes outside AWAIT_DATA never reach the engine. Abort after an error confirms that the error clears instead of sticking until reset.

// File: rtl/nin_cmd_pkg.sv
package nin_cmd_pkg;

    localparam int WORD_W = 32;
    localparam int OFS_W  = 3;
    localparam int FN_W   = 8;
    localparam int CODE_W = 3;

    localparam logic [FN_W-1:0] FN_DATAEND  = 8'd1;
    localparam logic [FN_W-1:0] FN_ENDNOW   = 8'd2;
    localparam logic [FN_W-1:0] FN_RESPOND  = 8'd3;
    localparam logic [FN_W-1:0] FN_RESPFIN  = 8'd4;
    localparam logic [FN_W-1:0] FN_ABORT    = 8'd5;

    localparam int CFG_DUMMY_LSB = 0;
    localparam int CFG_STAGE_LSB = 8;
    localparam int CFG_NODE_LSB  = 16;
    localparam int CFG_POLL_BIT  = 31;

    localparam int ST_BUSY  = 0;
    localparam int ST_WDATA = 1;
    localparam int ST_WCMD  = 2;
    localparam int ST_ERR   = 3;
    localparam int ST_DRAIN = 4;
    localparam int ST_FINAL = 5;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_AWAIT_CMD,
        CS_AWAIT_DATA,
        CS_DRAIN
    } conn_state_e;

    typedef enum logic {
        BS_IDLE,
        BS_DONE
    } bus_state_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_OP,
        RG_CFG,
        RG_STATE,
        RG_ACK,
        RG_DATA
    } reg_sel_e;

endpackage

// File: rtl/nin_addr_dec.sv
module nin_addr_dec
    import nin_cmd_pkg::*;
#(
    parameter int              AW          = 22,
    parameter logic [AW-1:0]   MASTER_BASE = 22'h000080,
    parameter logic [AW-1:0]   SLAVE_BASE  = 22'h000088,
    parameter bit              IS_SLAVE    = 1'b0
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    localparam int REGION_W = AW - OFS_W;

    logic [REGION_W-1:0] region;

    generate
        if (IS_SLAVE) begin : g_slave_region
            assign region = SLAVE_BASE[AW-1:OFS_W];
        end else begin : g_master_region
            assign region = MASTER_BASE[AW-1:OFS_W];
        end
    endgenerate

    always_comb begin
        sel = RG_NONE;
        if (addr[AW-1:OFS_W] == region) begin
            case (addr[OFS_W-1:0])
                3'd0:    sel = RG_OP;
                3'd1:    sel = RG_CFG;
                3'd2:    sel = RG_STATE;
                3'd3:    sel = RG_ACK;
                3'd4:    sel = RG_DATA;
                default: sel = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/nin_conn_fsm.sv
module nin_conn_fsm
    import nin_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_we,
    input  logic [WORD_W-1:0]   op_word,
    input  logic                data_we,
    input  logic [WORD_W-1:0]   data_word,
    input  logic                conn_open,
    input  logic                ack_valid,
    output conn_state_e         state,
    output logic                final_q,
    output logic                err_q,
    output logic                cmd_valid,
    output logic [CODE_W-1:0]   cmd_code,
    output logic                dat_valid,
    output logic [WORD_W-1:0]   dat_word
);

    logic [FN_W-1:0] fn;
    logic            upper_zero;
    logic            fn_defined;
    logic            fn_legal;
    logic            op_take;
    logic            op_bad;
    logic            take_abort;
    conn_state_e     state_nxt;
    logic            final_nxt;

    assign fn         = op_word[FN_W-1:0];
    assign upper_zero = (op_word[WORD_W-1:FN_W] == '0);
    assign fn_defined = (fn >= FN_DATAEND) && (fn <= FN_ABORT);

    // Which well-formed functions the current state accepts
    always_comb begin
        fn_legal = 1'b0;
        if (fn == FN_ABORT) begin
            fn_legal = 1'b1;
        end else begin
            unique case (state)
                CS_IDLE:       fn_legal = 1'b0;
                CS_AWAIT_CMD:  fn_legal = (fn == FN_RESPOND) || (fn == FN_RESPFIN) ||
                                          (fn == FN_ENDNOW);
                CS_AWAIT_DATA: fn_legal = (fn == FN_DATAEND);
                CS_DRAIN:      fn_legal = 1'b0;
            endcase
        end
    end

    assign op_bad     = op_we && !(upper_zero && fn_defined);
    assign op_take    = op_we && upper_zero && fn_defined && fn_legal;
    assign take_abort = op_take && (fn == FN_ABORT);

    // Next-state logic: abort first, then per-state transitions
    always_comb begin
        state_nxt = state;
        final_nxt = final_q;
        if (take_abort) begin
            state_nxt = CS_IDLE;
            final_nxt = 1'b0;
        end else begin
            unique case (state)
                CS_IDLE: begin
                    if (conn_open) begin
                        state_nxt = CS_AWAIT_CMD;
                        final_nxt = 1'b0;
                    end
                end
                CS_AWAIT_CMD: begin
                    if (op_take) begin
                        if (fn == FN_RESPOND) begin
                            state_nxt = CS_AWAIT_DATA;
                            final_nxt = 1'b0;
                        end else if (fn == FN_RESPFIN) begin
                            state_nxt = CS_AWAIT_DATA;
                            final_nxt = 1'b1;
                        end else begin
                            state_nxt = CS_IDLE;
                            final_nxt = 1'b0;
                        end
                    end
                end
                CS_AWAIT_DATA: begin
                    if (op_take) begin
                        state_nxt = CS_DRAIN;
                    end
                end
                CS_DRAIN: begin
                    if (ack_valid) begin
                        state_nxt = final_q ? CS_IDLE : CS_AWAIT_CMD;
                        if (final_q) begin
                            final_nxt = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= CS_IDLE;
            final_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state   <= state_nxt;
            final_q <= final_nxt;
            if (op_bad) begin
                err_q <= 1'b1;
            end else if (take_abort) begin
                err_q <= 1'b0;
            end
        end
    end

    // Output pulses to the transaction engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
            dat_valid <= 1'b0;
            dat_word  <= '0;
        end else begin
            cmd_valid <= op_take;
            if (op_take) begin
                cmd_code <= fn[CODE_W-1:0];
            end
            dat_valid <= data_we && (state == CS_AWAIT_DATA);
            if (data_we && (state == CS_AWAIT_DATA)) begin
                dat_word <= data_word;
            end
        end
    end

    // R3: the error only ever rises on a command write
    a_r3_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(op_we));

    // R4: forwarded codes are always in the defined range
    a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_code >= 3'd1 && cmd_code <= 3'd5));

    // R5: open from idle without a competing write reaches AWAIT_CMD
    a_r5_open_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_IDLE && conn_open && !op_we) |=> state == CS_AWAIT_CMD);

    // R7: a data pulse only follows a cycle spent in AWAIT_DATA
    a_r7_data_gated: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> $past(state) == CS_AWAIT_DATA);

    // R8: DRAIN holds until an acknowledge or a command write
    a_r8_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_DRAIN && !ack_valid && !op_we) |=> state == CS_DRAIN);

    // R9: abort lands in idle with the error cleared
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_we && op_word == 32'd5) |=> (state == CS_IDLE && !err_q && !final_q));

endmodule

// File: rtl/nin_cfg_regs.sv
module nin_cfg_regs
    import nin_cmd_pkg::*;
#(
    parameter int DUMMY_W = 6,
    parameter int STAGE_W = 4,
    parameter int NODE_W  = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [DUMMY_W-1:0]  wr_dummy,
    input  logic [STAGE_W-1:0]  wr_stages,
    input  logic [NODE_W-1:0]   wr_node,
    input  logic                wr_polled,
    input  logic                ack_valid,
    input  logic                ack_ok,
    output logic [DUMMY_W-1:0]  cfg_dummy,
    output logic [STAGE_W-1:0]  cfg_stages,
    output logic [NODE_W-1:0]   cfg_node,
    output logic                cfg_polled,
    output logic [WORD_W-1:0]   cfg_word,
    output logic                ack_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_dummy  <= '0;
            cfg_stages <= '0;
            cfg_node   <= '0;
            cfg_polled <= 1'b0;
        end else if (cfg_we) begin
            cfg_dummy  <= wr_dummy;
            cfg_stages <= wr_stages;
            cfg_node   <= wr_node;
            cfg_polled <= wr_polled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (ack_valid) begin
            ack_q <= ack_ok;
        end
    end

    always_comb begin
        cfg_word = '0;
        cfg_word[CFG_DUMMY_LSB +: DUMMY_W] = cfg_dummy;
        cfg_word[CFG_STAGE_LSB +: STAGE_W] = cfg_stages;
        cfg_word[CFG_NODE_LSB  +: NODE_W]  = cfg_node;
        cfg_word[CFG_POLL_BIT]             = cfg_polled;
    end

    // R11: configuration moves only on a whole-word write
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_word));

    // R12: acknowledge bit moves only on an engine acknowledge
    a_r12_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_valid |=> $stable(ack_q));

endmodule

// File: rtl/netin_cmd_port.sv
module netin_cmd_port
    import nin_cmd_pkg::*;
#(
    parameter int             AW          = 22,
    parameter logic [AW-1:0]  MASTER_BASE = 22'h000080,
    parameter logic [AW-1:0]  SLAVE_BASE  = 22'h000088,
    parameter bit             IS_SLAVE    = 1'b0,
    parameter int             DUMMY_W     = 6,
    parameter int             STAGE_W     = 4,
    parameter int             NODE_W      = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [AW-1:0]       bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_ready,
    input  logic                conn_open,
    input  logic                ack_valid,
    input  logic                ack_ok,
    input  logic [31:0]         rx_word,
    output logic                rx_pop,
    output logic                cmd_valid,
    output logic [2:0]          cmd_code,
    output logic                dat_valid,
    output logic [31:0]         dat_word,
    output logic [DUMMY_W-1:0]  cfg_dummy,
    output logic [STAGE_W-1:0]  cfg_stages,
    output logic [NODE_W-1:0]   cfg_node,
    output logic                cfg_polled,
    output logic                err_irq
);

    bus_state_e          bstate;
    bus_state_e          bstate_nxt;
    reg_sel_e            rsel;
    logic                acc;
    conn_state_e         cstate;
    logic                final_q;
    logic                err_q;
    logic                ack_q;
    logic [WORD_W-1:0]   cfg_word;
    logic [WORD_W-1:0]   state_word;
    logic [WORD_W-1:0]   rd_mux;

    nin_addr_dec #(
        .AW          (AW),
        .MASTER_BASE (MASTER_BASE),
        .SLAVE_BASE  (SLAVE_BASE),
        .IS_SLAVE    (IS_SLAVE)
    ) u_dec (
        .addr (bus_addr),
        .sel  (rsel)
    );

    // Bus handshake machine
    assign acc = bus_sel && (bstate == BS_IDLE);

    always_comb begin
        bstate_nxt = bstate;
        unique case (bstate)
            BS_IDLE: if (bus_sel) bstate_nxt = BS_DONE;
            BS_DONE: bstate_nxt = BS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bstate <= BS_IDLE;
        end else begin
            bstate <= bstate_nxt;
        end
    end

    assign bus_ready = (bstate == BS_DONE);

    nin_conn_fsm u_conn (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_we     (acc && bus_we && (rsel == RG_OP)),
        .op_word   (bus_wdata),
        .data_we   (acc && bus_we && (rsel == RG_DATA)),
        .data_word (bus_wdata),
        .conn_open (conn_open),
        .ack_valid (ack_valid),
        .state     (cstate),
        .final_q   (final_q),
        .err_q     (err_q),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .dat_valid (dat_valid),
        .dat_word  (dat_word)
    );

    nin_cfg_regs #(
        .DUMMY_W (DUMMY_W),
        .STAGE_W (STAGE_W),
        .NODE_W  (NODE_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (acc && bus_we && (rsel == RG_CFG)),
        .wr_dummy   (bus_wdata[CFG_DUMMY_LSB +: DUMMY_W]),
        .wr_stages  (bus_wdata[CFG_STAGE_LSB +: STAGE_W]),
        .wr_node    (bus_wdata[CFG_NODE_LSB +: NODE_W]),
        .wr_polled  (bus_wdata[CFG_POLL_BIT]),
        .ack_valid  (ack_valid),
        .ack_ok     (ack_ok),
        .cfg_dummy  (cfg_dummy),
        .cfg_stages (cfg_stages),
        .cfg_node   (cfg_node),
        .cfg_polled (cfg_polled),
        .cfg_word   (cfg_word),
        .ack_q      (ack_q)
    );

    assign err_irq = err_q;

    always_comb begin
        state_word           = '0;
        state_word[ST_BUSY]  = (cstate != CS_IDLE);
        state_word[ST_WDATA] = (cstate == CS_AWAIT_DATA);
        state_word[ST_WCMD]  = (cstate == CS_AWAIT_CMD);
        state_word[ST_ERR]   = err_q;
        state_word[ST_DRAIN] = (cstate == CS_DRAIN);
        state_word[ST_FINAL] = final_q;
    end

    always_comb begin
        rd_mux = '0;
        case (rsel)
            RG_CFG:   rd_mux = cfg_word;
            RG_STATE: rd_mux = state_word;
            RG_ACK:   rd_mux = {{(WORD_W-1){1'b0}}, ack_q};
            RG_DATA:  rd_mux = rx_word;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            rx_pop    <= 1'b0;
        end else begin
            rx_pop <= acc && !bus_we && (rsel == RG_DATA);
            if (acc) begin
                bus_rdata <= bus_we ? '0 : rd_mux;
            end
        end
    end

    // R2: ready is a single-cycle pulse
    a_r2_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R2: ready only answers a request
    a_r2_ready_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_sel));

    // R4: commands leave together with the access completion
    a_r4_cmd_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> bus_ready);

    // R14: a pop only completes a read
    a_r14_pop_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> bus_ready);

endmodule

// File: tb/netin_cmd_port_tb.sv
module netin_cmd_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] MB = 22'h000080;
    localparam logic [21:0] SB = 22'h000088;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [21:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        conn_open = 1'b0;
    logic        ack_valid = 1'b0;
    logic        ack_ok = 1'b0;
    logic [31:0] rx_word = '0;
    logic        rx_pop;
    logic        cmd_valid;
    logic [2:0]  cmd_code;
    logic        dat_valid;
    logic [31:0] dat_word;
    logic [5:0]  cfg_dummy;
    logic [3:0]  cfg_stages;
    logic [11:0] cfg_node;
    logic        cfg_polled;
    logic        err_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] g_rd;
    logic        g_pre_ready, g_ready, g_cmdv, g_datv, g_pop;
    logic [2:0]  g_cmd;
    logic [31:0] g_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    netin_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .conn_open(conn_open), .ack_valid(ack_valid),
        .ack_ok(ack_ok), .rx_word(rx_word), .rx_pop(rx_pop),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .dat_valid(dat_valid),
        .dat_word(dat_word), .cfg_dummy(cfg_dummy), .cfg_stages(cfg_stages),
        .cfg_node(cfg_node), .cfg_polled(cfg_polled), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [21:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        g_pre_ready = bus_ready;
        @(negedge clk);
        g_ready = bus_ready; g_rd = bus_rdata; g_cmdv = cmd_valid; g_cmd = cmd_code;
        g_datv = dat_valid; g_dat = dat_word; g_pop = rx_pop;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [21:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [21:0] a);
        access(1'b0, a, 32'h0);
    endtask

    task automatic open_conn();
        @(negedge clk); conn_open = 1'b1;
        @(negedge clk); conn_open = 1'b0;
    endtask

    task automatic send_ack(input logic ok);
        @(negedge clk); ack_valid = 1'b1; ack_ok = ok;
        @(negedge clk); ack_valid = 1'b0;
    endtask

    function automatic logic [31:0] cfg_exp(input logic [31:0] w);
        return (w & 32'h0000_003F) | (w & 32'h0000_0F00) |
               (w & 32'h0FFF_0000) | (w & 32'h8000_0000);
    endfunction

    // state word: busy=1, await data=2, await cmd=4, err=8, drain=16, final=32
    localparam logic [31:0] S_IDLE  = 32'd0;
    localparam logic [31:0] S_WCMD  = 32'd5;
    localparam logic [31:0] S_WDATA = 32'd3;
    localparam logic [31:0] S_DRAIN = 32'd17;
    localparam logic [31:0] S_FINAL = 32'd32;
    localparam logic [31:0] S_ERR   = 32'd8;

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // reset state (R2, R11, R13, R12)
        chk("R2 ready idle in reset", {31'b0, bus_ready}, 32'd0);
        chk("R11 cfg reset", {cfg_polled, 7'b0, cfg_node, cfg_stages, 2'b0, cfg_dummy}, 32'd0);
        chk("R3 err reset", {31'b0, err_irq}, 32'd0);
        rst_n = 1'b1;
        rd(MB + 22'd2);
        chk("R2 ready low before edge", {31'b0, g_pre_ready}, 32'd0);
        chk("R2 ready in completion cycle", {31'b0, g_ready}, 32'd1);
        chk("R13 state after reset", g_rd, S_IDLE);
        @(negedge clk);
        chk("R2 ready drops after one cycle", {31'b0, bus_ready}, 32'd0);
        rd(MB + 22'd3);
        chk("R12 ack reset", g_rd, 32'd0);
        rd(MB + 22'd1);
        chk("R11 cfg readback reset", g_rd, 32'd0);

        // R11 configuration patterns
        for (int i = 0; i < 16; i++) begin
            logic [31:0] p;
            p = (i == 0) ? 32'hFFFF_FFFF : (32'(i) * 32'h9E37_79B9);
            wr(MB + 22'd1, p);
            chk("R11 cfg dummy", {26'b0, cfg_dummy}, (p >> 0) & 32'h3F);
            chk("R11 cfg stages", {28'b0, cfg_stages}, (p >> 8) & 32'hF);
            chk("R11 cfg node", {20'b0, cfg_node}, (p >> 16) & 32'hFFF);
            chk("R11 cfg polled", {31'b0, cfg_polled}, (p >> 31) & 32'h1);
            rd(MB + 22'd1);
            chk("R11 cfg readback", g_rd, cfg_exp(p));
        end
        wr(MB + 22'd1, 32'h0000_0000);

        // R1 aliasing: slave region, unused offsets, next region
        for (int k = 0; k < 8; k++) begin
            wr(SB + 22'(k), 32'hFFFF_FFFF);
            chk("R1 slave write ignored cfg", {cfg_polled, 7'b0, cfg_node, cfg_stages, 2'b0, cfg_dummy}, 32'd0);
            chk("R1 slave write no cmd", {31'b0, g_cmdv}, 32'd0);
            chk("R1 slave write ready", {31'b0, g_ready}, 32'd1);
            rx_word = 32'hA5A5_0000 + 32'(k);
            rd(SB + 22'(k));
            chk("R1 slave read zero", g_rd, 32'd0);
            chk("R1 slave read no pop", {31'b0, g_pop}, 32'd0);
        end
        for (int k = 5; k < 8; k++) begin
            wr(MB + 22'(k), 32'd5);
            chk("R1 unused offset no cmd", {31'b0, g_cmdv}, 32'd0);
            rd(MB + 22'(k));
            chk("R1 unused offset reads zero", g_rd, 32'd0);
        end
        wr(MB + 22'd9, 32'hFFFF_FFFF);
        chk("R1 next region no cfg", {31'b0, cfg_polled}, 32'd0);

        // R14 data read
        rx_word = 32'hDEAD_BEEF;
        rd(MB + 22'd4);
        chk("R14 data read value", g_rd, 32'hDEAD_BEEF);
        chk("R14 data read pops", {31'b0, g_pop}, 32'd1);
        rd(MB + 22'd2);
        chk("R14 other read no pop", {31'b0, g_pop}, 32'd0);

        // R12 acknowledge
        send_ack(1'b1);
        rd(MB + 22'd3);
        chk("R12 ack ok", g_rd, 32'd1);
        send_ack(1'b0);
        rd(MB + 22'd3);
        chk("R12 ack failed", g_rd, 32'd0);

        // R10 out-of-place in idle
        wr(MB, 32'd1);
        chk("R10 dataend idle no cmd", {31'b0, g_cmdv}, 32'd0);
        wr(MB, 32'd3);
        chk("R10 respond idle no cmd", {31'b0, g_cmdv}, 32'd0);
        rd(MB + 22'd2);
        chk("R10 idle unchanged", g_rd, S_IDLE);

        // R3 R4 R5 R6 R10: sweep every low-byte code from AWAIT_CMD
        for (int c = 0; c < 256; c++) begin
            logic [31:0] exp_st;
            logic        exp_cmd;
            wr(MB, 32'd5);
            chk("R9 abort cmd", {29'b0, g_cmd}, 32'd5);
            open_conn();
            if (c == 0) begin
                rd(MB + 22'd2);
                chk("R5 open enters await cmd", g_rd, S_WCMD);
            end
            wr(MB, 32'(c));
            case (c)
                1:       begin exp_cmd = 1'b0; exp_st = S_WCMD; end
                2:       begin exp_cmd = 1'b1; exp_st = S_IDLE; end
                3:       begin exp_cmd = 1'b1; exp_st = S_WDATA; end
                4:       begin exp_cmd = 1'b1; exp_st = S_WDATA | S_FINAL; end
                5:       begin exp_cmd = 1'b1; exp_st = S_IDLE; end
                default: begin exp_cmd = 1'b0; exp_st = S_WCMD | S_ERR; end
            endcase
            chk("R4 R3 cmd pulse", {31'b0, g_cmdv}, {31'b0, exp_cmd});
            if (exp_cmd) chk("R4 cmd code", {29'b0, g_cmd}, 32'(c));
            chk("R3 err_irq", {31'b0, err_irq}, {31'b0, (c < 1 || c > 5)});
            rd(MB + 22'd2);
            chk("R6 R10 R3 state after code", g_rd, exp_st);
        end

        // R3 polluted upper bytes
        for (int b = 8; b < 32; b++) begin
            wr(MB, 32'd5);
            open_conn();
            wr(MB, (32'd1 << b) | 32'd3);
            chk("R3 upper bits no cmd", {31'b0, g_cmdv}, 32'd0);
            chk("R3 upper bits err", {31'b0, err_irq}, 32'd1);
            rd(MB + 22'd2);
            chk("R3 upper bits state", g_rd, S_WCMD | S_ERR);
        end

        // R9 abort clears the error
        wr(MB, 32'd5);
        rd(MB + 22'd2);
        chk("R9 abort clears err", g_rd, S_IDLE);
        chk("R9 err_irq low", {31'b0, err_irq}, 32'd0);

        // R7 R8 two-turn reply flow
        open_conn();
        wr(MB + 22'd4, 32'h1111_1111);
        chk("R7 data in await cmd dropped", {31'b0, g_datv}, 32'd0);
        wr(MB, 32'd3);
        for (int j = 0; j < 3; j++) begin
            wr(MB + 22'd4, 32'hC0DE_0000 + 32'(j));
            chk("R7 data pulse", {31'b0, g_datv}, 32'd1);
            chk("R7 data word", g_dat, 32'hC0DE_0000 + 32'(j));
        end
        wr(MB, 32'd1);
        chk("R8 dataend cmd", {29'b0, g_cmd}, 32'd1);
        rd(MB + 22'd2);
        chk("R8 drain state", g_rd, S_DRAIN);
        wr(MB + 22'd4, 32'h2222_2222);
        chk("R7 data in drain dropped", {31'b0, g_datv}, 32'd0);
        send_ack(1'b1);
        rd(MB + 22'd2);
        chk("R8 turn back to await cmd", g_rd, S_WCMD);
        wr(MB, 32'd4);
        wr(MB + 22'd4, 32'h3333_3333);
        chk("R7 data after final respond", g_dat, 32'h3333_3333);
        wr(MB, 32'd1);
        rd(MB + 22'd2);
        chk("R8 final drain state", g_rd, S_DRAIN | S_FINAL);
        send_ack(1'b0);
        rd(MB + 22'd2);
        chk("R8 final ack to idle", g_rd, S_IDLE);
        rd(MB + 22'd3);
        chk("R12 ack from flow", g_rd, 32'd0);
        wr(MB + 22'd4, 32'h4444_4444);
        chk("R7 data in idle dropped", {31'b0, g_datv}, 32'd0);

        // R9 abort from AWAIT_DATA, R6 ENDNOW
        open_conn();
        wr(MB, 32'd3);
        wr(MB, 32'd5);
        rd(MB + 22'd2);
        chk("R9 abort from await data", g_rd, S_IDLE);
        open_conn();
        wr(MB, 32'd2);
        chk("R6 endnow cmd", {29'b0, g_cmd}, 32'd2);
        rd(MB + 22'd2);
        chk("R6 endnow to idle", g_rd, S_IDLE);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule